// File: doc/BRIEF.md
# I2C Command Receiver with Status Snapshot

This block is the slave end of a two-wire serial command link running at fast-mode rates. It watches SCL and SDA from an oversampling system clock, removes short spikes from both lines and recognises START and STOP conditions. It then matches a 7-bit address, three bits of which come from strap inputs, and acknowledges the bytes it takes. Bytes the master writes leave the block as a valid/ready byte stream toward a command decoder. The first byte after the address is flagged, and a one-cycle pulse marks the STOP that closes a write frame.

The stream side has one holding register. A byte waits in it, held stable with `cmd_valid` high, until the decoder raises `cmd_ready`. There is no clock stretching, so the block cannot stall the bus. If another byte finishes on the bus while the holding register is still full, the block answers that byte with NACK and discards it. The decoder therefore applies back-pressure only by causing NACKs.

A read transfer returns a status byte taken from a snapshot register. The snapshot copies `status_in` only when a write frame's first byte is the status-read command 0xB0. At all other times the snapshot holds its value, so repeated reads return the same byte. SDA is open-drain: `sda_oe` high means the block pulls the line low.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The address byte is sent MSB first as A6..A0 followed by a direction bit. The address matches when A6..A4 equal `strap_addr[2:1:0]` (A6 = strap bit 2) and A3..A0 equal 4'b0101. On a match the block pulls SDA low for the ninth clock.
- R2: After an address mismatch the block leaves SDA released, acknowledges nothing and delivers no byte until the next START.
- R3: With direction bit 0, each data byte is acknowledged and appears once on `cmd_data`, in bus order. `cmd_first` is 1 only for the first data byte after the address.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_data` and `cmd_first` hold. A byte that completes while the holding register is full is answered with NACK and is not delivered.
- R5: A STOP that closes an addressed write frame gives `cmd_end` high for exactly one cycle. Unaddressed and read frames give no pulse.
- R6: The status snapshot loads `status_in` only when an accepted first data byte of a write frame equals 0xB0. Otherwise it keeps its value, including when 0xB0 arrives as a later byte.
- R7: With direction bit 1, the block drives the snapshot MSB first for each byte while the master ACKs. After a master NACK it releases SDA and drives nothing until the next START.
- R8: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks (56 ns by default at 4 ns per clock, which covers the 50 ns spike limit) changes no bus state.
- R9: A START seen in the middle of a byte abandons the partial byte and restarts address reception.
- R10: After reset `sda_oe`, `cmd_valid` and `cmd_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 3 | Upper three address bits (A6..A4) |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| status_in | input | 8 | Live status offered to the snapshot |
| cmd_valid | output | 1 | Holding register carries a byte |
| cmd_ready | input | 1 | Decoder accepts the byte this cycle |
| cmd_data | output | 8 | Received command byte |
| cmd_first | output | 1 | Byte is the first of its write frame |
| cmd_end | output | 1 | One-cycle pulse on STOP after a write frame |

## Verification
Every bus edge reaches the state machine about `FILT_CYC` + 3 clocks after it occurs on the pins. An acknowledge or read bit therefore appears at most about 18 clocks after the raw SCL fall. A received byte enters the holding register on the same filtered fall. The bench uses a quarter-bit phase of 20 clocks, larger than that delay. It samples the wired SDA in the middle of each SCL high phase, and it reads the stream and `cmd_end` at falling clock edges. It checks the collected bytes only after the STOP, when every result from the transfer is due.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } eng_state_t;

  localparam int BYTE_BITS = 8;
  localparam logic [3:0] ADDR_LOW_DEFAULT = 4'b0101;
  localparam logic [7:0] STATUS_CMD_DEFAULT = 8'hB0;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // The output follows the synchronised input only after the input has
  // differed from it for FILT_CYC consecutive clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] != dout) begin
        if (run_q == CW'(FILT_CYC - 1)) begin
          dout  <= sync_q[1];
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    ev_start = scl_f && scl_q && sda_q && !sda_f;
    ev_stop  = scl_f && scl_q && !sda_q && sda_f;
    ev_rise  = scl_f && !scl_q;
    ev_fall  = !scl_f && scl_q;
  end
endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
  import i2cs_pkg::*;
#(
  parameter logic [3:0] ADDR_LOW   = ADDR_LOW_DEFAULT,
  parameter logic [7:0] STATUS_CMD = STATUS_CMD_DEFAULT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic       sda_f,
  input  logic [2:0] strap_addr,
  input  logic [7:0] status_snap,
  input  logic       cmd_ready,
  output logic       cmd_valid,
  output logic [7:0] cmd_data,
  output logic       cmd_first,
  output logic       cmd_end,
  output logic       sda_oe,
  output logic       snap_load
);
  localparam int CNTW = $clog2(BYTE_BITS + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(BYTE_BITS);
  localparam logic [CNTW-1:0] LAST_RD  = CNTW'(BYTE_BITS - 1);

  eng_state_t      st_q;
  logic [7:0]      sh_q;
  logic [CNTW-1:0] cnt_q;
  logic            rw_q, first_q, mack_q;
  logic            byte_done, accept, push;

  always_comb begin
    byte_done = (st_q == ST_WR_DATA) && ev_fall && (cnt_q == FULL_CNT)
                && !ev_start && !ev_stop;
    accept    = !cmd_valid || cmd_ready;
    push      = byte_done && accept;
  end

  // Bus-side state machine.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
      cmd_end <= 1'b0;
    end else begin
      cmd_end <= 1'b0;
      if (ev_start) begin
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        sda_oe <= 1'b0;
      end else if (ev_stop) begin
        st_q    <= ST_IDLE;
        sda_oe  <= 1'b0;
        cmd_end <= (st_q == ST_WR_DATA) || (st_q == ST_WR_ACK);
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_fall && cnt_q == FULL_CNT) begin
              if (sh_q[7:1] == {strap_addr, ADDR_LOW}) begin
                rw_q   <= sh_q[0];
                sda_oe <= 1'b1;
                st_q   <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q   <= status_snap;
                sda_oe <= ~status_snap[7];
                st_q   <= ST_RD_DATA;
              end else begin
                sda_oe  <= 1'b0;
                first_q <= 1'b1;
                st_q    <= ST_WR_DATA;
              end
            end
          end
          ST_WR_DATA: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              sda_oe  <= accept;
              first_q <= 1'b0;
              st_q    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (ev_fall) begin
              sda_oe <= 1'b0;
              cnt_q  <= '0;
              st_q   <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (ev_fall) begin
              if (cnt_q == LAST_RD) begin
                sda_oe <= 1'b0;
                st_q   <= ST_RD_ACK;
              end else begin
                cnt_q  <= cnt_q + 1'b1;
                sh_q   <= {sh_q[6:0], 1'b0};
                sda_oe <= ~sh_q[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (ev_rise) begin
              mack_q <= ~sda_f;
            end else if (ev_fall) begin
              if (mack_q) begin
                sh_q   <= status_snap;
                sda_oe <= ~status_snap[7];
                cnt_q  <= '0;
                st_q   <= ST_RD_DATA;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Stream-side holding register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      cmd_first <= 1'b0;
      snap_load <= 1'b0;
    end else begin
      snap_load <= push && first_q && (sh_q == STATUS_CMD);
      if (push) begin
        cmd_valid <= 1'b1;
        cmd_data  <= sh_q;
        cmd_first <= first_q;
      end else if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cs_status_snap.sv
module i2cs_status_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] status_in,
  output logic [W-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap <= '0;
    else if (load) snap <= status_in;
  end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2cs_pkg::*;
#(
  parameter int         FILT_CYC   = 14,
  parameter logic [3:0] ADDR_LOW   = ADDR_LOW_DEFAULT,
  parameter logic [7:0] STATUS_CMD = STATUS_CMD_DEFAULT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_addr,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [7:0] status_in,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_data,
  output logic       cmd_first,
  output logic       cmd_end
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, flt_lines;
  logic scl_flt, sda_flt;
  logic ev_start, ev_stop, ev_rise, ev_fall;
  logic snap_load;
  logic [7:0] status_snap;

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cs_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  i2cs_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_flt),
    .sda_f   (sda_flt),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .ev_rise (ev_rise),
    .ev_fall (ev_fall)
  );

  i2cs_byte_engine #(.ADDR_LOW(ADDR_LOW), .STATUS_CMD(STATUS_CMD)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_rise    (ev_rise),
    .ev_fall    (ev_fall),
    .sda_f      (sda_flt),
    .strap_addr (strap_addr),
    .status_snap(status_snap),
    .cmd_ready  (cmd_ready),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .cmd_first  (cmd_first),
    .cmd_end    (cmd_end),
    .sda_oe     (sda_oe),
    .snap_load  (snap_load)
  );

  i2cs_status_snap #(.W(8)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (snap_load),
    .status_in(status_in),
    .snap     (status_snap)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       cmd_first,
  input logic       cmd_end,
  input logic       sda_oe,
  input logic       scl_f,
  input logic       snap_load,
  input logic [7:0] snap
);
  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data) && $stable(cmd_first)));

  assert_end_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> !cmd_end);

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(snap));

  assert_oe_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  assert_idle_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_end) |-> !sda_oe);
endmodule

bind i2c_cmd_slave i2cs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_data (cmd_data),
  .cmd_first(cmd_first),
  .cmd_end  (cmd_end),
  .sda_oe   (sda_oe),
  .scl_f    (scl_flt),
  .snap_load(snap_load),
  .snap     (status_snap)
);

// File: tb/test_i2c_cmd_slave.sv
`timescale 1ns/1ps
module test_i2c_cmd_slave;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap = 3'b000;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [7:0] status_in = 8'h00;
  logic       rdy = 1'b1;
  logic       sda_oe, cmd_valid, cmd_first, cmd_end;
  logic [7:0] cmd_data;
  logic       sda_line;

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [8:0] rec [0:63];
  int nrec = 0, nend = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_cmd_slave i_i2c_cmd_slave (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .status_in(status_in), .cmd_valid(cmd_valid), .cmd_ready(rdy),
    .cmd_data(cmd_data), .cmd_first(cmd_first), .cmd_end(cmd_end)
  );

  always @(negedge clk) begin
    if (rst_n && cmd_valid && rdy && nrec < 64) begin
      rec[nrec] = {cmd_first, cmd_data};
      nrec++;
    end
    if (rst_n && cmd_end) nend++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
    end
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2 * Q);
  endtask

  // gk: 0 none, 1 SDA spike while SCL high, 2 SCL spike while SCL low
  task automatic write_bit(input bit b, input int gk);
    sda_m = b; wt(Q);
    scl_m = 1'b1;
    if (gk == 1) begin
      wt(10); sda_m = ~b; wt(8); sda_m = b; wt(2 * Q - 18);
    end else begin
      wt(2 * Q);
    end
    scl_m = 1'b0;
    if (gk == 2) begin
      wt(5); scl_m = 1'b1; wt(8); scl_m = 1'b0; wt(Q - 13);
    end else begin
      wt(Q);
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack, input int gbit, input int gk);
    for (int i = 7; i >= 0; i--) write_bit(b[i], (i == gbit) ? gk : 0);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    ack = ~sda_line; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic read_byte(output logic [7:0] v, input bit give_nack);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl_m = 1'b1; wt(Q);
      v = {v[6:0], sda_line};
      wt(Q); scl_m = 1'b0; wt(Q);
    end
    sda_m = give_nack; wt(Q);
    scl_m = 1'b1; wt(2 * Q);
    scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  task automatic check_rec(input int idx, input logic [7:0] b, input bit f, input string tag);
    chk(nrec > idx && rec[idx] == {f, b}, tag, (nrec > idx) ? int'(rec[idx]) : -1, int'({f, b}));
  endtask

  initial begin
    bit ack, exp_ack;
    logic [7:0] v;
    logic [6:0] a;
    int base, ends0;

    wt(5);
    chk(sda_oe == 1'b0 && cmd_valid == 1'b0 && cmd_end == 1'b0, "R10 reset outputs",
        {sda_oe, cmd_valid, cmd_end}, 0);
    rst_n = 1'b1;
    wt(5);

    // R1/R2 sweep over straps and address candidates
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      wt(4);
      for (int u = 0; u < 9; u++) begin
        a = (u < 8) ? {3'(u), 4'b0101} : {3'(s), 4'b0100};
        exp_ack = (a[6:4] == 3'(s)) && (a[3:0] == 4'b0101);
        bus_start();
        write_byte({a, 1'b0}, ack, -1, 0);
        chk(ack == exp_ack, exp_ack ? "R1 address ack" : "R2 mismatch no ack", ack, exp_ack);
        if (!exp_ack && s == 5 && u == 0) begin
          write_byte(8'h77, ack, -1, 0);
          chk(ack == 1'b0, "R2 data after mismatch not acked", ack, 0);
        end
        bus_stop();
      end
    end
    chk(nrec == 0, "R2 no bytes from address frames", nrec, 0);
    chk(nend == 8, "R5 end pulses only for matched write frames", nend, 8);

    strap = 3'b010;
    a = {3'b010, 4'b0101};

    // R3 multi-byte write
    base = nrec; ends0 = nend;
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    write_byte(8'h12, ack, -1, 0); chk(ack, "R3 byte0 ack", ack, 1);
    write_byte(8'h34, ack, -1, 0); chk(ack, "R3 byte1 ack", ack, 1);
    write_byte(8'h56, ack, -1, 0); chk(ack, "R3 byte2 ack", ack, 1);
    bus_stop();
    check_rec(base,     8'h12, 1'b1, "R3 first byte");
    check_rec(base + 1, 8'h34, 1'b0, "R3 second byte");
    check_rec(base + 2, 8'h56, 1'b0, "R3 third byte");
    chk(nrec == base + 3, "R3 byte count", nrec - base, 3);
    chk(nend == ends0 + 1, "R5 one end pulse", nend - ends0, 1);

    // R4 back-pressure
    rdy = 1'b0;
    base = nrec;
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    write_byte(8'h21, ack, -1, 0); chk(ack, "R4 held byte acked", ack, 1);
    write_byte(8'h43, ack, -1, 0); chk(!ack, "R4 full holding nacks", ack, 0);
    bus_stop();
    chk(cmd_valid && cmd_data == 8'h21 && cmd_first, "R4 holding content",
        {cmd_valid, cmd_first, cmd_data}, {2'b11, 8'h21});
    rdy = 1'b1;
    wt(4);
    check_rec(base, 8'h21, 1'b1, "R4 released byte");
    chk(nrec == base + 1, "R4 dropped byte absent", nrec - base, 1);

    // R6/R7 status snapshot and repeated reads
    status_in = 8'h5A;
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    write_byte(8'hB0, ack, -1, 0);
    bus_stop();
    status_in = 8'hFF;
    ends0 = nend;
    bus_start();
    write_byte({a, 1'b1}, ack, -1, 0);
    chk(ack, "R7 read address ack", ack, 1);
    read_byte(v, 1'b0); chk(v == 8'h5A, "R7 read byte0", v, 8'h5A);
    read_byte(v, 1'b0); chk(v == 8'h5A, "R7 read byte1", v, 8'h5A);
    read_byte(v, 1'b1); chk(v == 8'h5A, "R7 read byte2", v, 8'h5A);
    wt(Q); scl_m = 1'b1; wt(Q);
    chk(sda_line == 1'b1, "R7 released after nack", sda_line, 1);
    wt(Q); scl_m = 1'b0; wt(Q);
    bus_stop();
    chk(nend == ends0, "R5 no end pulse after read", nend - ends0, 0);

    // R6: command in second position does not refresh
    status_in = 8'h3C;
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    write_byte(8'h10, ack, -1, 0);
    write_byte(8'hB0, ack, -1, 0);
    bus_stop();
    bus_start();
    write_byte({a, 1'b1}, ack, -1, 0);
    read_byte(v, 1'b1);
    bus_stop();
    chk(v == 8'h5A, "R6 snapshot held", v, 8'h5A);

    // R8 spike rejection
    base = nrec;
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    write_byte(8'hA5, ack, 7, 1); chk(ack, "R8 sda spike byte acked", ack, 1);
    write_byte(8'h96, ack, 2, 2); chk(ack, "R8 scl spike byte acked", ack, 1);
    bus_stop();
    check_rec(base,     8'hA5, 1'b1, "R8 sda spike ignored");
    check_rec(base + 1, 8'h96, 1'b0, "R8 scl spike ignored");

    // R9 repeated START in the middle of a byte
    base = nrec;
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    write_bit(1'b1, 0); write_bit(1'b0, 0); write_bit(1'b1, 0); write_bit(1'b1, 0);
    bus_start();
    write_byte({a, 1'b0}, ack, -1, 0);
    chk(ack, "R9 address after restart acked", ack, 1);
    write_byte(8'h3C, ack, -1, 0);
    bus_stop();
    check_rec(base, 8'h3C, 1'b1, "R9 byte after restart");
    chk(nrec == base + 1, "R9 partial byte dropped", nrec - base, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule